// File: doc/BRIEF.md
# Ternary Logic Operator Unit

A purely combinational datapath block that applies one three-valued logic operator, chosen by a 4-bit opcode, to every trit position of two trit vectors at once. Each trit travels on a two-bit binary code, so an operand of `NUM_TRITS` trits occupies `2*NUM_TRITS` wires. The result comes out in the same cycle, with no register on the path.

Eleven operators are offered. Five are unary and read operand A alone: the simple, positive and negative inverters and the forward and reverse diode functions. Six are binary: maximum, minimum, their simple-inverted forms, the carry-free modulo-3 sum and its simple inverse. A single error output reports any opcode outside that set, and any unused wire code on a trit that the chosen operator reads.

Top module: `tern_logic_unit`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = 1, 2'b10 = 2, and 2'b11 is invalid. No result trit is ever 2'b11.
- R2: Opcode 0 (simple inverse) gives 2 minus the A trit in every position.
- R3: Opcode 1 (positive inverse) gives 0 for an A trit of 2 and gives 2 otherwise. Opcode 2 (negative inverse) gives 2 for an A trit of 0 and gives 0 otherwise.
- R4: Opcode 3 (forward diode) gives 2 for an A trit of 2 and gives 1 otherwise. Opcode 4 (reverse diode) gives 0 for an A trit of 0 and gives 1 otherwise.
- R5: Opcode 5 gives the larger of the A and B trits, and opcode 6 gives the smaller. As a consequence, 0 is the identity for the larger-of operator and 2 absorbs it, while 2 is the identity for the smaller-of operator and 0 absorbs it.
- R6: Opcode 7 gives 2 minus the larger of A and B. Opcode 8 gives 2 minus the smaller of A and B.
- R7: Opcode 9 gives (A + B) mod 3 per trit, with no carry between positions. Opcode 10 gives 2 minus that value.
- R8: Opcodes 0 to 4 ignore operand B entirely. The result does not depend on B, and an invalid code in B does not raise err_o.
- R9: An invalid code in a trit that the operator reads forces that result trit to 0 and raises err_o. All other trit positions are computed as usual.
- R10: Opcodes 11 to 15 drive every result trit to 0 and raise err_o. With a valid opcode and valid operand trits, err_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*NUM_TRITS | Operand A; trit k is bits [2k+1:2k] |
| b_i | input | 2*NUM_TRITS | Operand B; not read by opcodes 0 to 4 |
| op_i | input | 4 | Operator select |
| res_o | output | 2*NUM_TRITS | Result vector, same packing as the operands |
| err_o | output | 1 | Invalid opcode, or invalid code in a trit that is read |

## Verification
Two kinds of vector are applied. Directed vectors step through the trit pairs so that each operator meets every input value in some position. This tells apart the three inverters, which differ only in where they send 0, 1 and 2, and it separates the diode functions from the inverters. Identity and absorbing operands show whether the larger-of and smaller-of operators have their roles swapped. Invalid codes placed in only one trit show whether a fault stays local to its position, whether B is truly ignored by the unary operators, and whether the error flag is set only by operands that the operator reads. Seeded random vectors then mix every opcode, including the unused ones, with occasional invalid codes.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_ONE  = 2'b01;
  localparam trit_t T_TWO  = 2'b10;
  localparam trit_t T_BAD  = 2'b11;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SINV = 4'd0,
    OP_PINV = 4'd1,
    OP_NINV = 4'd2,
    OP_FDIO = 4'd3,
    OP_RDIO = 4'd4,
    OP_MAX  = 4'd5,
    OP_MIN  = 4'd6,
    OP_NMAX = 4'd7,
    OP_NMIN = 4'd8,
    OP_SUM  = 4'd9,
    OP_NSUM = 4'd10
  } op_e;

  function automatic trit_t simple_inv(trit_t t);
    return T_TWO - t;
  endfunction
endpackage

// File: rtl/tlu_op_decode.sv
module tlu_op_decode
  import tlu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            unary_o,
  output logic            bad_op_o
);
  always_comb begin
    unary_o  = (op_i <= OP_RDIO);
    bad_op_o = (op_i > OP_NSUM);
  end
endmodule

// File: rtl/tlu_trit_cell.sv
module tlu_trit_cell
  import tlu_pkg::*;
(
  input  trit_t           a_i,
  input  trit_t           b_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            unary_i,
  input  logic            bad_op_i,
  output trit_t           res_o,
  output logic            err_o
);
  logic       a_bad, b_bad, use_bad;
  trit_t      t_max, t_min, t_mod;
  logic [2:0] t_sum;
  trit_t      t_val;

  always_comb begin
    a_bad   = (a_i == T_BAD);
    b_bad   = (b_i == T_BAD) && !unary_i;
    use_bad = a_bad || b_bad;

    t_max = (a_i > b_i) ? a_i : b_i;
    t_min = (a_i < b_i) ? a_i : b_i;
    t_sum = {1'b0, a_i} + {1'b0, b_i};
    t_mod = (t_sum >= 3'd3) ? 2'(t_sum - 3'd3) : t_sum[1:0];

    unique case (op_i)
      OP_SINV: t_val = simple_inv(a_i);
      OP_PINV: t_val = (a_i == T_TWO)  ? T_ZERO : T_TWO;
      OP_NINV: t_val = (a_i == T_ZERO) ? T_TWO  : T_ZERO;
      OP_FDIO: t_val = (a_i == T_TWO)  ? T_TWO  : T_ONE;
      OP_RDIO: t_val = (a_i == T_ZERO) ? T_ZERO : T_ONE;
      OP_MAX:  t_val = t_max;
      OP_MIN:  t_val = t_min;
      OP_NMAX: t_val = simple_inv(t_max);
      OP_NMIN: t_val = simple_inv(t_min);
      OP_SUM:  t_val = t_mod;
      OP_NSUM: t_val = simple_inv(t_mod);
      default: t_val = T_ZERO;
    endcase

    // invalid input or opcode squashes this trit
    res_o = (use_bad || bad_op_i) ? T_ZERO : t_val;
    err_o = use_bad && !bad_op_i;
  end
endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tlu_pkg::*;
#(
  parameter int unsigned NUM_TRITS = 8,
  localparam int unsigned VEC_W = 2 * NUM_TRITS
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [VEC_W-1:0] res_o,
  output logic             err_o
);
  logic                 unary, bad_op;
  logic [NUM_TRITS-1:0] trit_err;

  tlu_op_decode i_dec (
    .op_i    (op_i),
    .unary_o (unary),
    .bad_op_o(bad_op)
  );

  for (genvar g = 0; g < NUM_TRITS; g++) begin : g_trit
    tlu_trit_cell i_cell (
      .a_i     (a_i[2*g +: 2]),
      .b_i     (b_i[2*g +: 2]),
      .op_i    (op_i),
      .unary_i (unary),
      .bad_op_i(bad_op),
      .res_o   (res_o[2*g +: 2]),
      .err_o   (trit_err[g])
    );
  end

  assign err_o = bad_op || (|trit_err);
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
  parameter int unsigned NUM_TRITS = 8
) (
  input logic [2*NUM_TRITS-1:0] a_i,
  input logic [2*NUM_TRITS-1:0] b_i,
  input logic [3:0]             op_i,
  input logic [2*NUM_TRITS-1:0] res_o,
  input logic                   err_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, res_o, err_o})) begin
      AST_BAD_OP: assert (!(op_i > 4'd10) || (res_o == '0 && err_o)); // R10
      for (int k = 0; k < NUM_TRITS; k++) begin
        int ta, tb, tr;
        ta = int'(a_i[2*k +: 2]);
        tb = int'(b_i[2*k +: 2]);
        tr = int'(res_o[2*k +: 2]);
        AST_RES_LEGAL: assert (tr != 3); // R1
        AST_SINV_SUM: assert (!(op_i == 4'd0 && ta != 3) || (tr + ta == 2)); // R2
        AST_MAX_BOUND: assert (!(op_i == 4'd5 && ta != 3 && tb != 3) ||
                               (tr >= ta && tr >= tb && (tr == ta || tr == tb))); // R5
        AST_SUM_MOD: assert (!(op_i == 4'd9 && ta != 3 && tb != 3) ||
                             ((tr + 6 - ta - tb) % 3 == 0)); // R7
        AST_BAD_TRIT: assert (!(ta == 3 && op_i <= 4'd10) || (tr == 0 && err_o)); // R9
      end
    end
  end

  always_comb begin
    if (!$isunknown({a_i, op_i, err_o})) begin
      logic a_ok;
      a_ok = 1'b1;
      for (int k = 0; k < NUM_TRITS; k++)
        if (a_i[2*k +: 2] == 2'b11) a_ok = 1'b0;
      AST_UNARY_NO_ERR: assert (!(op_i <= 4'd4 && a_ok) || !err_o); // R8
    end
  end
endmodule

bind tern_logic_unit tlu_checker #(.NUM_TRITS(NUM_TRITS)) i_tlu_checker (
  .a_i  (a_i),
  .b_i  (b_i),
  .op_i (op_i),
  .res_o(res_o),
  .err_o(err_o)
);

// File: tb/test_tern_logic_unit.sv
module test_tern_logic_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2*N-1:0] a, b, res;
  logic [3:0] op;
  logic err;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tern_logic_unit #(.NUM_TRITS(N)) i_tern_logic_unit (
    .a_i(a), .b_i(b), .op_i(op), .res_o(res), .err_o(err)
  );

  function automatic int inv2(int v);
    return 2 - v;
  endfunction

  // returns {err, result}; err only for invalid operands that are read
  function automatic logic [2:0] ref_trit(int o, int ta, int tb);
    int r;
    bit un;
    un = (o <= 4);
    if (o > 10) return 3'b000;
    if (ta == 3 || (!un && tb == 3)) return 3'b100;
    case (o)
      0: r = inv2(ta);
      1: r = (ta == 2) ? 0 : 2;
      2: r = (ta == 0) ? 2 : 0;
      3: r = (ta == 2) ? 2 : 1;
      4: r = (ta == 0) ? 0 : 1;
      5: r = (ta > tb) ? ta : tb;
      6: r = (ta < tb) ? ta : tb;
      7: r = inv2((ta > tb) ? ta : tb);
      8: r = inv2((ta < tb) ? ta : tb);
      9: r = (ta + tb) % 3;
      default: r = inv2((ta + tb) % 3);
    endcase
    return {1'b0, 2'(r)};
  endfunction

  task automatic drive(logic [3:0] o, logic [2*N-1:0] va, logic [2*N-1:0] vb);
    @(negedge clk);
    op = o; a = va; b = vb;
    #(CLK_PERIOD/4);
  endtask

  task automatic check(string tag);
    logic [2*N-1:0] exp_r;
    logic exp_e;
    logic [2:0] t;
    exp_r = '0;
    exp_e = (op > 4'd10);
    for (int k = 0; k < N; k++) begin
      t = ref_trit(int'(op), int'(a[2*k +: 2]), int'(b[2*k +: 2]));
      exp_r[2*k +: 2] = t[1:0];
      if (t[2]) exp_e = 1'b1;
    end
    n_run++;
    if (res !== exp_r || err !== exp_e) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h: res=%h err=%b expected res=%h err=%b",
               tag, op, a, b, res, err, exp_r, exp_e);
    end
  endtask

  // trit k of A = (k+sa)%3, of B = (k/3+sb)%3
  function automatic logic [2*N-1:0] pat(int s, bit hi);
    logic [2*N-1:0] v;
    for (int k = 0; k < N; k++)
      v[2*k +: 2] = hi ? 2'((k/3 + s) % 3) : 2'((k + s) % 3);
    return v;
  endfunction

  function automatic logic [2*N-1:0] fill(logic [1:0] t);
    logic [2*N-1:0] v;
    for (int k = 0; k < N; k++) v[2*k +: 2] = t;
    return v;
  endfunction

  function automatic logic [2*N-1:0] rnd_vec();
    logic [2*N-1:0] v;
    for (int k = 0; k < N; k++) begin
      int r;
      r = int'($urandom % 16);
      v[2*k +: 2] = (r == 0) ? 2'b11 : 2'(r % 3);
    end
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    op = 4'd0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #(CLK_PERIOD/4);
    check("R2 reset state");

    for (int s = 0; s < 3; s++) begin
      drive(4'd0, pat(s, 0), pat(s, 1)); check("R2 simple inverse");
      drive(4'd1, pat(s, 0), pat(s, 1)); check("R3 positive inverse");
      drive(4'd2, pat(s, 0), pat(s, 1)); check("R3 negative inverse");
      drive(4'd3, pat(s, 0), pat(s, 1)); check("R4 forward diode");
      drive(4'd4, pat(s, 0), pat(s, 1)); check("R4 reverse diode");
      drive(4'd5, pat(s, 0), pat(s, 1)); check("R5 max");
      drive(4'd6, pat(s, 0), pat(s, 1)); check("R5 min");
      drive(4'd7, pat(s, 0), pat(s, 1)); check("R6 inverted max");
      drive(4'd8, pat(s, 0), pat(s, 1)); check("R6 inverted min");
      drive(4'd9, pat(s, 0), pat(s, 1)); check("R7 mod-3 sum");
      drive(4'd10, pat(s, 0), pat(s, 1)); check("R7 inverted sum");
    end

    drive(4'd5, pat(1, 0), fill(2'b00)); check("R5 max identity 0");
    drive(4'd5, pat(1, 0), fill(2'b10)); check("R5 max absorbs 2");
    drive(4'd6, pat(2, 0), fill(2'b10)); check("R5 min identity 2");
    drive(4'd6, pat(2, 0), fill(2'b00)); check("R5 min absorbs 0");

    for (int o = 0; o < 5; o++) begin
      drive(4'(o), pat(0, 0), fill(2'b11)); check("R8 unary ignores invalid B");
      drive(4'(o), pat(0, 0), pat(2, 1)); check("R8 unary ignores B");
    end

    drive(4'd5, pat(0, 0) | 16'h0030, pat(1, 1)); check("R9 invalid A trit");
    drive(4'd9, pat(1, 0), pat(0, 1) | 16'hC000); check("R9 invalid B trit");
    drive(4'd0, fill(2'b11), pat(0, 1)); check("R9 all A invalid");

    for (int o = 11; o < 16; o++) begin
      drive(4'(o), pat(o % 3, 0), pat(0, 1)); check("R10 unused opcode");
    end

    for (int i = 0; i < 400; i++) begin
      drive(4'($urandom % 16), rnd_vec(), rnd_vec());
      check("R1 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule